// File: doc/BRIEF.md
# Combined Waveform Selector

This block turns the upper bits of a 24-bit phase accumulator into a 12-bit oscillator output. Four independent enables choose among a triangle, a sawtooth, a pulse and a noise source. Any subset of the four may be on together. The selected sources are merged with an ideal digital AND model, so a zero in any enabled source forces that output bit to zero. Each source also keeps its own structural quirks:

- The triangle's lowest bit is tied low.
- Turning on the sawtooth removes the triangle's fold inversion.
- The noise source leaves its four low bits at zero.

The output is registered and appears one clock after its inputs. A second registered output, `msb_clear`, is a one-cycle active-high strobe. The owner of the accumulator uses it to clear the accumulator MSB. It fires only in the early silicon variant, which is selected by a parameter. In that variant, a combined output whose top bit is low drags down a sawtooth top bit that is high. Analog pull-down strengths are not modelled.

Top module: `wave_mix_top`

## Requirements
- R1: While `rst_n` is low, `wave_out` is 12'h000 and `msb_clear` is 0.
- R2: With all four enables low, `wave_out` is 12'h000 one cycle later.
- R3: With only the sawtooth enabled, `wave_out` equals `acc_phase[23:12]` one cycle later.
- R4: With only the triangle enabled, `wave_out[11:1]` is `acc_phase[22:12]` XOR a fold bit and `wave_out[0]` is 0. The fold bit is `acc_phase[23]` when `ring_on` is 0 and `ring_src_msb` when `ring_on` is 1.
- R5: With only the pulse enabled, `wave_out` is 12'hFFF when `acc_phase[23:12] >= pulse_level` (equality included) or when `test_hold` is 1. Otherwise it is 12'h000.
- R6: With only the noise enabled, `wave_out` is `{noise_bits[7:0], 4'b0000}`.
- R7: With several enables high, `wave_out` is the bitwise AND of the enabled sources. While the sawtooth is enabled, the triangle source is `{acc_phase[22:12], 1'b0}` with no fold.
- R8: With exactly sawtooth and triangle enabled, `wave_out` is `S & (S << 1)` truncated to 12 bits, where S is `acc_phase[23:12]`.
- R9: With `MODEL_EARLY` = 1, `msb_clear` is 1 exactly when three things hold together: the sawtooth is enabled, `acc_phase[23]` is 1, and the combined output bit 11 is 0. It is valid in the same cycle as the matching `wave_out`. With `MODEL_EARLY` = 0, `msb_clear` stays 0.
- R10: Both outputs are registered. A change on any input shows up at the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_phase | input | 24 | Phase accumulator value |
| sel_tri | input | 1 | Triangle enable |
| sel_saw | input | 1 | Sawtooth enable |
| sel_pulse | input | 1 | Pulse enable |
| sel_noise | input | 1 | Noise enable |
| pulse_level | input | 12 | Pulse width compare value |
| ring_src_msb | input | 1 | MSB of the modulating oscillator |
| ring_on | input | 1 | Ring modulation mode for the triangle fold |
| test_hold | input | 1 | Test bit, forces the pulse source high |
| noise_bits | input | 8 | Current noise register output |
| wave_out | output | 12 | Registered combined waveform |
| msb_clear | output | 1 | Registered accumulator MSB clear strobe |

## Verification
The hardest case to reach from the ports is the clear strobe. It needs the sawtooth enabled, the accumulator MSB high, and another enabled source that zeroes bit 11 in the same cycle. That happens when the sawtooth is combined with a low pulse, with noise whose top bit is clear, or with the triangle at 12'h800. Directed vectors build each of these cases. A second instance built as the late variant receives the same stimulus and must never raise the strobe. Pulse equality at the compare value and the test override are set up directly. A long random sweep of enable subsets then compares every cycle against the behavioural model.

// File: rtl/wavemix_pkg.sv
package wavemix_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_TRG = 0;
  localparam int SRC_SAW = 1;
  localparam int SRC_PUL = 2;
  localparam int SRC_NOI = 3;
endpackage

// File: rtl/wm_sources.sv
module wm_sources #(
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 12,
  parameter int NOISE_W = 8
) (
  input  logic [ACC_W-1:0]   acc,
  input  logic               saw_on,
  input  logic [OUT_W-1:0]   level,
  input  logic               ring_msb,
  input  logic               ring_mode,
  input  logic               force_hi,
  input  logic [NOISE_W-1:0] noise,
  output logic [OUT_W-1:0]   src_trg,
  output logic [OUT_W-1:0]   src_saw,
  output logic [OUT_W-1:0]   src_pul,
  output logic [OUT_W-1:0]   src_noi
);
  localparam int TOP = ACC_W - 1;
  localparam int LOW = ACC_W - OUT_W;
  localparam int PAD = OUT_W - NOISE_W;

  function automatic logic [OUT_W-1:0] f_saw(input logic [ACC_W-1:0] a);
    return a[TOP:LOW];
  endfunction

  // Fold inversion is removed when the sawtooth is on; bit 0 is always low.
  function automatic logic [OUT_W-1:0] f_trg(input logic [ACC_W-1:0] a,
                                             input logic fold, input logic no_xor);
    logic [OUT_W-2:0] body;
    body = a[TOP-1:LOW];
    if (!no_xor) body = body ^ {(OUT_W-1){fold}};
    return {body, 1'b0};
  endfunction

  function automatic logic [OUT_W-1:0] f_pul(input logic [ACC_W-1:0] a,
                                             input logic [OUT_W-1:0] lv, input logic frc);
    return (frc || (a[TOP:LOW] >= lv)) ? {OUT_W{1'b1}} : {OUT_W{1'b0}};
  endfunction

  function automatic logic [OUT_W-1:0] f_noi(input logic [NOISE_W-1:0] n);
    return {n, {PAD{1'b0}}};
  endfunction

  logic fold_bit;
  assign fold_bit = ring_mode ? ring_msb : acc[TOP];

  assign src_saw = f_saw(acc);
  assign src_trg = f_trg(acc, fold_bit, saw_on);
  assign src_pul = f_pul(acc, level, force_hi);
  assign src_noi = f_noi(noise);
endmodule

// File: rtl/wm_combiner.sv
module wm_combiner
  import wavemix_pkg::*;
#(
  parameter int OUT_W       = 12,
  parameter bit MODEL_EARLY = 1'b1
) (
  input  logic [NUM_SRC-1:0]            en,
  input  logic [NUM_SRC-1:0][OUT_W-1:0] src,
  output logic [OUT_W-1:0]              mixed,
  output logic                          any_on,
  output logic                          wb_hit
);
  logic [NUM_SRC-1:0][OUT_W-1:0] masked;
  logic [OUT_W-1:0]              and_all;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    assign masked[i] = en[i] ? src[i] : {OUT_W{1'b1}};
  end

  always_comb begin
    and_all = {OUT_W{1'b1}};
    for (int i = 0; i < NUM_SRC; i++) and_all = and_all & masked[i];
  end

  assign any_on = |en;
  assign mixed  = any_on ? and_all : {OUT_W{1'b0}};

  if (MODEL_EARLY) begin : g_early
    assign wb_hit = en[SRC_SAW] && src[SRC_SAW][OUT_W-1] && !mixed[OUT_W-1];
  end else begin : g_late
    assign wb_hit = 1'b0;
  end
endmodule

// File: rtl/wave_mix_top.sv
module wave_mix_top
  import wavemix_pkg::*;
#(
  parameter int ACC_W       = 24,
  parameter int OUT_W       = 12,
  parameter int NOISE_W     = 8,
  parameter bit MODEL_EARLY = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACC_W-1:0]   acc_phase,
  input  logic               sel_tri,
  input  logic               sel_saw,
  input  logic               sel_pulse,
  input  logic               sel_noise,
  input  logic [OUT_W-1:0]   pulse_level,
  input  logic               ring_src_msb,
  input  logic               ring_on,
  input  logic               test_hold,
  input  logic [NOISE_W-1:0] noise_bits,
  output logic [OUT_W-1:0]   wave_out,
  output logic               msb_clear
);
  logic [OUT_W-1:0]              src_trg, src_saw, src_pul, src_noi;
  logic [NUM_SRC-1:0]            sel_vec;
  logic [NUM_SRC-1:0][OUT_W-1:0] src_vec;
  logic [OUT_W-1:0]              mixed;
  logic                          any_sel;
  logic                          wb_hit;

  assign sel_vec[SRC_TRG] = sel_tri;
  assign sel_vec[SRC_SAW] = sel_saw;
  assign sel_vec[SRC_PUL] = sel_pulse;
  assign sel_vec[SRC_NOI] = sel_noise;

  assign src_vec[SRC_TRG] = src_trg;
  assign src_vec[SRC_SAW] = src_saw;
  assign src_vec[SRC_PUL] = src_pul;
  assign src_vec[SRC_NOI] = src_noi;

  wm_sources #(.ACC_W(ACC_W), .OUT_W(OUT_W), .NOISE_W(NOISE_W)) u_src (
    .acc(acc_phase), .saw_on(sel_saw), .level(pulse_level),
    .ring_msb(ring_src_msb), .ring_mode(ring_on), .force_hi(test_hold),
    .noise(noise_bits),
    .src_trg(src_trg), .src_saw(src_saw), .src_pul(src_pul), .src_noi(src_noi)
  );

  wm_combiner #(.OUT_W(OUT_W), .MODEL_EARLY(MODEL_EARLY)) u_mix (
    .en(sel_vec), .src(src_vec), .mixed(mixed), .any_on(any_sel), .wb_hit(wb_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_out  <= '0;
      msb_clear <= 1'b0;
    end else begin
      wave_out  <= mixed;
      msb_clear <= wb_hit;
    end
  end
endmodule

// File: rtl/wm_checker.sv
module wm_checker #(
  parameter int ACC_W       = 24,
  parameter int OUT_W       = 12,
  parameter bit MODEL_EARLY = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] acc_phase,
  input logic             sel_tri,
  input logic             sel_saw,
  input logic             sel_pulse,
  input logic             sel_noise,
  input logic             test_hold,
  input logic [OUT_W-1:0] wave_out,
  input logic             msb_clear,
  input logic             any_sel,
  input logic             wb_hit
);
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_sel |=> (wave_out == '0));

  assert_saw_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_saw && !sel_tri && !sel_pulse && !sel_noise)
      |=> (wave_out == $past(acc_phase[ACC_W-1:ACC_W-OUT_W])));

  assert_trg_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tri |=> (wave_out[0] == 1'b0));

  assert_test_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pulse && test_hold && !sel_tri && !sel_saw && !sel_noise)
      |=> (wave_out == {OUT_W{1'b1}}));

  assert_noise_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_noise |=> (wave_out[3:0] == 4'h0));

  assert_and_saw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_saw |=> ((wave_out & ~$past(acc_phase[ACC_W-1:ACC_W-OUT_W])) == '0));

  assert_clear_top_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msb_clear |-> (wave_out[OUT_W-1] == 1'b0));

  assert_clear_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msb_clear |-> ($past(sel_saw) && $past(acc_phase[ACC_W-1])));

  assert_clear_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_hit |=> msb_clear);

  assert_late_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (MODEL_EARLY == 1'b0) |-> !msb_clear);
endmodule

bind wave_mix_top wm_checker #(
  .ACC_W(ACC_W), .OUT_W(OUT_W), .MODEL_EARLY(MODEL_EARLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_phase(acc_phase),
  .sel_tri(sel_tri), .sel_saw(sel_saw), .sel_pulse(sel_pulse), .sel_noise(sel_noise),
  .test_hold(test_hold), .wave_out(wave_out), .msb_clear(msb_clear),
  .any_sel(any_sel), .wb_hit(wb_hit)
);

// File: tb/wave_mix_top_test.sv
`timescale 1ns/1ps
module wave_mix_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] acc_phase = '0;
  logic        sel_tri = 0, sel_saw = 0, sel_pulse = 0, sel_noise = 0;
  logic [11:0] pulse_level = '0;
  logic        ring_src_msb = 0, ring_on = 0, test_hold = 0;
  logic [7:0]  noise_bits = '0;
  logic [11:0] wave_out, wave_late;
  logic        msb_clear, clear_late;

  int checks = 0;
  int errors = 0;
  int exp_wave = 0;
  int exp_clr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wave_mix_top uut (
    .clk(clk), .rst_n(rst_n), .acc_phase(acc_phase),
    .sel_tri(sel_tri), .sel_saw(sel_saw), .sel_pulse(sel_pulse), .sel_noise(sel_noise),
    .pulse_level(pulse_level), .ring_src_msb(ring_src_msb), .ring_on(ring_on),
    .test_hold(test_hold), .noise_bits(noise_bits),
    .wave_out(wave_out), .msb_clear(msb_clear)
  );

  wave_mix_top #(.MODEL_EARLY(1'b0)) uut_late (
    .clk(clk), .rst_n(rst_n), .acc_phase(acc_phase),
    .sel_tri(sel_tri), .sel_saw(sel_saw), .sel_pulse(sel_pulse), .sel_noise(sel_noise),
    .pulse_level(pulse_level), .ring_src_msb(ring_src_msb), .ring_on(ring_on),
    .test_hold(test_hold), .noise_bits(noise_bits),
    .wave_out(wave_late), .msb_clear(clear_late)
  );

  // Behavioural reference: each output bit evaluated independently with integers.
  task automatic model();
    int ph, res, bitv, any;
    ph  = acc_phase / 4096;
    res = 0;
    any = sel_tri + sel_saw + sel_pulse + sel_noise;
    for (int b = 0; b < 12; b++) begin
      bitv = 1;
      if (sel_saw) bitv = bitv & ((ph >> b) & 1);
      if (sel_tri) begin
        if (b == 0) bitv = 0;
        else begin
          int f;
          f = sel_saw ? 0 : (ring_on ? ring_src_msb : ((ph >> 11) & 1));
          bitv = bitv & ((((ph >> (b - 1)) & 1)) ^ f);
        end
      end
      if (sel_pulse) bitv = bitv & ((test_hold || ph >= pulse_level) ? 1 : 0);
      if (sel_noise) bitv = bitv & ((b < 4) ? 0 : ((noise_bits >> (b - 4)) & 1));
      if (any != 0 && bitv != 0) res = res + (1 << b);
    end
    exp_wave = res;
    exp_clr  = (sel_saw && ((ph >> 11) & 1) && !((res >> 11) & 1)) ? 1 : 0;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Hold inputs across one rising edge, then compare at the falling edge (R10).
  task automatic step(input string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    check({tag, " wave"}, wave_out, exp_wave);
    check({tag, " clear"}, msb_clear, exp_clr);
    check({tag, " late wave"}, wave_late, exp_wave);
    check({tag, " late clear R9"}, clear_late, 0);
  endtask

  task automatic set_sel(input logic t, input logic s, input logic p, input logic n);
    sel_tri = t; sel_saw = s; sel_pulse = p; sel_noise = n;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: inputs active during reset, outputs stay cleared
    set_sel(0, 1, 1, 0); acc_phase = 24'hFFF000;
    repeat (3) @(negedge clk);
    check("R1 wave", wave_out, 0);
    check("R1 clear", msb_clear, 0);
    rst_n = 1'b1;

    set_sel(0, 0, 0, 0); acc_phase = 24'hABC123; step("R2 idle");
    set_sel(0, 1, 0, 0); acc_phase = 24'h5A3FFF; step("R3 saw");
    check("R3 value", wave_out, 12'h5A3);
    set_sel(1, 0, 0, 0); acc_phase = 24'h9A3000; step("R4 fold high");
    check("R4 value", wave_out, 12'hCB8);
    acc_phase = 24'h1A3000; step("R4 rising");
    ring_on = 1; ring_src_msb = 1; step("R4 ring");
    ring_on = 0; ring_src_msb = 0;
    set_sel(0, 0, 1, 0); pulse_level = 12'h400; acc_phase = 24'h400000; step("R5 equal");
    check("R5 equal value", wave_out, 12'hFFF);
    acc_phase = 24'h3FF000; step("R5 below");
    check("R5 below value", wave_out, 12'h000);
    test_hold = 1; step("R5 test");
    test_hold = 0;
    set_sel(0, 0, 0, 1); noise_bits = 8'hA5; step("R6 noise");
    check("R6 value", wave_out, 12'hA50);
    set_sel(1, 1, 0, 0); acc_phase = 24'hB6D000; step("R8 saw tri");
    check("R8 value", wave_out, 12'h248);
    acc_phase = 24'h800000; step("R8 top R9 clear");
    set_sel(1, 0, 0, 1); acc_phase = 24'h7F0000; noise_bits = 8'hFF; step("R7 tri noise");
    set_sel(0, 1, 1, 0); pulse_level = 12'hF00; acc_phase = 24'hC00000; step("R9 saw pulse low");
    check("R9 strobe", msb_clear, 1);
    pulse_level = 12'h100; step("R9 saw pulse high");
    set_sel(0, 1, 0, 1); noise_bits = 8'h7F; step("R9 saw noise");
    set_sel(1, 1, 1, 1); pulse_level = 12'h000; acc_phase = 24'hFFF000; noise_bits = 8'hFF;
    step("R7 all four");

    for (int i = 0; i < 3000; i++) begin
      set_sel($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 1));
      acc_phase    = 24'($urandom);
      pulse_level  = 12'($urandom);
      noise_bits   = 8'($urandom);
      ring_on      = 1'($urandom);
      ring_src_msb = 1'($urandom);
      test_hold    = ($urandom_range(0, 7) == 0);
      step("R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule